// File: doc/BRIEF.md
# Software-Managed TLB Lookup

This block is a fully associative translation buffer whose contents are loaded by software, one word at a time, through a write port. Each entry has three parts. A tag word holds the effective page number, a valid flag and a page-size code. A data word holds the real page number, a zone selector and two permission bits. An 8-bit process tag is taken from the current process identifier whenever the tag word is written.

A lookup is purely combinational. The lookup takes a virtual address and the current process identifier. In the same cycle it returns the following:
- whether any entry hit, and the index of the entry that won;
- the physical page base, trimmed by a configurable physical address mask;
- the page size as a power of two;
- a 2-bit access code read out of a zone protection vector;
- the entry's permission bits, passed through unchanged;
- an error flag when the winning entry has a page smaller than the minimum supported size.

Page sizes vary per entry. A process tag of zero makes an entry global. Zone selectors beyond the configured zone count are clamped to a fixed access code.

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an entry is written with its valid bit set.
- R2: An entry takes part in matching only while bit 6 of its last written tag word is 1. Rewriting the tag with bit 6 at 0 removes the entry from matching.
- R3: Tag bits [9:7] hold a size code c, and the page holds 2^(10+2c) bytes (1 KB up to 16 MB). An entry matches when virtual address bits [31:10+2c] equal the same bits of the tag word.
- R4: An entry with a nonzero process tag matches only when `cur_pid` equals that tag. An entry with process tag zero matches any `cur_pid`.
- R5: A tag-word write records `cur_pid` as the entry's process tag. A data-word write leaves the process tag unchanged.
- R6: The zone selector is data bits [7:4], written z. When z is at most NUM_ZONES (default 7), `lk_zone_acc` equals `zone_prot[2z+1:2z]`. When z is above NUM_ZONES, `lk_zone_acc` is 1.
- R7: On a hit, the outputs are formed as follows:
  - `lk_pa` is the data word bits [39:10] with bits [9:0] zero, ANDed with PA_MASK (default: bits [35:0] set).
  - `lk_size_log2` is 10+2c.
  - `lk_perm` is data bits [9:8].
- R8: When several entries match, the lowest index wins, and `lk_idx` reports that index.
- R9: `lk_size_err` is 1 exactly when there is a hit and the page size of the winning entry is below 2^MIN_PAGE_LOG2 (default 4 KB, so only size code 0 is flagged).
- R10: A write with `wr_sel`=0 loads the tag word and a write with `wr_sel`=1 loads the data word of entry `wr_idx`. The write takes effect at the clock edge, so a lookup in the same cycle still sees the old contents.
- R11: On a miss, `lk_hit`, `lk_idx`, `lk_pa`, `lk_size_log2`, `lk_zone_acc`, `lk_perm` and `lk_size_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one entry word |
| wr_sel | input | 1 | 0 selects the tag word, 1 selects the data word |
| wr_idx | input | 6 | Entry written |
| wr_word | input | 64 | Word to store |
| cur_pid | input | 8 | Current process identifier |
| zone_prot | input | 32 | Two access bits per zone, zone z at bits [2z+1:2z] |
| lk_vaddr | input | 32 | Virtual address looked up |
| lk_hit | output | 1 | Some entry matched |
| lk_idx | output | 6 | Winning entry index |
| lk_pa | output | 40 | Masked physical page base |
| lk_size_log2 | output | 5 | Page size as a power of two |
| lk_zone_acc | output | 2 | Zone-derived access code |
| lk_perm | output | 2 | Entry permission bits |
| lk_size_err | output | 1 | Winning page is below the minimum size |

## Verification
The function most likely to collide with a lookup is an entry write. Both can target the same entry in one cycle. The bench provokes this by driving, in a single cycle, a tag write that clears the valid bit of an entry together with a lookup that hits that entry. The scoreboard expects the same-cycle lookup to return the old hit. It then expects a miss from the identical lookup one cycle later. Overlapping matches are provoked with a 1 MB entry and a 16 KB entry that share addresses, and the lower index must win.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int WORD_W      = 64;
  localparam int PG_LSB      = 10;
  localparam int VALID_BIT   = 6;
  localparam int SZ_LSB      = 7;
  localparam int SZ_W        = 3;
  localparam int ZSEL_LSB    = 4;
  localparam int ZSEL_W      = 4;
  localparam int PERM_LSB    = 8;
  localparam int PTAG_W      = 8;
  localparam int ZPROT_W     = 2 << ZSEL_W;

  typedef enum logic {
    SEL_TAG  = 1'b0,
    SEL_DATA = 1'b1
  } word_sel_e;

  typedef logic [SZ_W-1:0] size_code_t;

  typedef struct packed {
    logic [1:0]        perm;
    logic [ZSEL_W-1:0] zsel;
  } attr_t;

  // byte size exponent of a page: 1 KB times four to the power of code
  function automatic logic [4:0] size_log2(input size_code_t code);
    return 5'd10 + {1'b0, code, 1'b0};
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int VA_W  = 32,
  parameter int PA_W  = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [WORD_W-1:0]       wr_word,
  input  logic [PTAG_W-1:0]       cur_pid,
  output logic [N-1:0]            valid_vec,
  output logic [VA_W-PG_LSB-1:0]  epn   [N],
  output size_code_t              code  [N],
  output logic [PTAG_W-1:0]       ptag  [N],
  output logic [PA_W-PG_LSB-1:0]  rpn   [N],
  output attr_t                   attr  [N]
);

  localparam int EPN_W = VA_W - PG_LSB;
  localparam int RPN_W = PA_W - PG_LSB;

  word_sel_e sel;
  assign sel = word_sel_e'(wr_sel);

  logic unused_wr;
  assign unused_wr = ^wr_word;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic              we_tag;
    logic              we_data;
    logic              valid_d;
    logic              valid_q;
    logic [EPN_W-1:0]  epn_q;
    size_code_t        code_q;
    logic [PTAG_W-1:0] ptag_q;
    logic [RPN_W-1:0]  rpn_q;
    attr_t             attr_q;

    assign we_tag  = wr_en && (wr_idx == IDX_W'(g)) && (sel == SEL_TAG);
    assign we_data = wr_en && (wr_idx == IDX_W'(g)) && (sel == SEL_DATA);

    always_comb begin
      valid_d = valid_q;
      if (we_tag) valid_d = wr_word[VALID_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
      if (we_tag) begin
        epn_q  <= wr_word[VA_W-1:PG_LSB];
        code_q <= wr_word[SZ_LSB +: SZ_W];
        ptag_q <= cur_pid;
      end
    end

    always_ff @(posedge clk) begin
      if (we_data) begin
        rpn_q       <= wr_word[PA_W-1:PG_LSB];
        attr_q.perm <= wr_word[PERM_LSB +: 2];
        attr_q.zsel <= wr_word[ZSEL_LSB +: ZSEL_W];
      end
    end

    assign valid_vec[g] = valid_q;
    assign epn[g]       = epn_q;
    assign code[g]      = code_q;
    assign ptag[g]      = ptag_q;
    assign rpn[g]       = rpn_q;
    assign attr[g]      = attr_q;
  end

endmodule

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
  import tlb_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic                   valid,
  input  logic [VA_W-PG_LSB-1:0] epn,
  input  size_code_t             code,
  input  logic [PTAG_W-1:0]      ptag,
  input  logic [VA_W-PG_LSB-1:0] vpage,
  input  logic [PTAG_W-1:0]      pid,
  output logic                   match
);

  localparam int EPN_W = VA_W - PG_LSB;

  logic [EPN_W-1:0] keep;
  logic             addr_eq;
  logic             pid_ok;

  // larger pages drop two more low page-number bits per size step
  assign keep    = {EPN_W{1'b1}} << {code, 1'b0};
  assign addr_eq = ((vpage ^ epn) & keep) == '0;
  assign pid_ok  = (ptag == '0) || (ptag == pid);
  assign match   = valid && addr_eq && pid_ok;

endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int ENTRIES       = 64,
  parameter int VA_W          = 32,
  parameter int PA_W          = 40,
  parameter int NUM_ZONES     = 7,
  parameter int MIN_PAGE_LOG2 = 12,
  parameter logic [PA_W-1:0] PA_MASK = {4'h0, {(PA_W-4){1'b1}}},
  localparam int IDX_W        = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [63:0]        wr_word,
  input  logic [7:0]         cur_pid,
  input  logic [31:0]        zone_prot,
  input  logic [VA_W-1:0]    lk_vaddr,
  output logic               lk_hit,
  output logic [IDX_W-1:0]   lk_idx,
  output logic [PA_W-1:0]    lk_pa,
  output logic [4:0]         lk_size_log2,
  output logic [1:0]         lk_zone_acc,
  output logic [1:0]         lk_perm,
  output logic               lk_size_err
);

  localparam int EPN_W = VA_W - PG_LSB;
  localparam int RPN_W = PA_W - PG_LSB;
  localparam logic [ZSEL_W-1:0] ZONE_LIM = ZSEL_W'(NUM_ZONES);
  localparam logic [4:0]        MIN_LG   = 5'(MIN_PAGE_LOG2);

  // reset: asserted at once, released through two flops
  logic rst_meta;
  logic rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [ENTRIES-1:0] ent_valid;
  logic [ENTRIES-1:0] ent_match;
  logic [EPN_W-1:0]   ent_epn  [ENTRIES];
  size_code_t         ent_code [ENTRIES];
  logic [PTAG_W-1:0]  ent_ptag [ENTRIES];
  logic [RPN_W-1:0]   ent_rpn  [ENTRIES];
  attr_t              ent_attr [ENTRIES];

  tlb_entry_store #(
    .N     (ENTRIES),
    .IDX_W (IDX_W),
    .VA_W  (VA_W),
    .PA_W  (PA_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_idx    (wr_idx),
    .wr_word   (wr_word),
    .cur_pid   (cur_pid),
    .valid_vec (ent_valid),
    .epn       (ent_epn),
    .code      (ent_code),
    .ptag      (ent_ptag),
    .rpn       (ent_rpn),
    .attr      (ent_attr)
  );

  logic [EPN_W-1:0] vpage;
  logic             unused_lk;
  assign vpage     = lk_vaddr[VA_W-1:PG_LSB];
  assign unused_lk = ^lk_vaddr[PG_LSB-1:0];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_match_cell #(.VA_W(VA_W)) u_cell (
      .valid (ent_valid[g]),
      .epn   (ent_epn[g]),
      .code  (ent_code[g]),
      .ptag  (ent_ptag[g]),
      .vpage (vpage),
      .pid   (cur_pid),
      .match (ent_match[g])
    );
  end

  logic             win_found;
  logic [IDX_W-1:0] win_idx;

  tlb_prio_sel #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req   (ent_match),
    .found (win_found),
    .idx   (win_idx)
  );

  logic [RPN_W-1:0]  win_rpn;
  attr_t             win_attr;
  size_code_t        win_code;
  logic [4:0]        win_lg;

  assign win_rpn  = ent_rpn[win_idx];
  assign win_attr = ent_attr[win_idx];
  assign win_code = ent_code[win_idx];
  assign win_lg   = size_log2(win_code);

  always_comb begin
    lk_hit       = 1'b0;
    lk_idx       = '0;
    lk_pa        = '0;
    lk_size_log2 = '0;
    lk_zone_acc  = '0;
    lk_perm      = '0;
    lk_size_err  = 1'b0;
    if (win_found) begin
      lk_hit       = 1'b1;
      lk_idx       = win_idx;
      lk_pa        = {win_rpn, {PG_LSB{1'b0}}} & PA_MASK;
      lk_size_log2 = win_lg;
      lk_perm      = win_attr.perm;
      lk_size_err  = win_lg < MIN_LG;
      if (win_attr.zsel > ZONE_LIM) lk_zone_acc = 2'd1;
      else                          lk_zone_acc = zone_prot[{win_attr.zsel, 1'b0} +: 2];
    end
  end

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int N     = 64,
  parameter int IDX_W = 6,
  parameter int PA_W  = 40,
  parameter logic [PA_W-1:0] PA_MASK = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx,
  input logic [PA_W-1:0]  lk_pa,
  input logic [4:0]       lk_size_log2,
  input logic [1:0]       lk_zone_acc,
  input logic [1:0]       lk_perm,
  input logic             lk_size_err,
  input logic [N-1:0]     valid_vec,
  input logic [N-1:0]     match_vec
);

  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_idx == '0 && lk_pa == '0 && lk_size_log2 == '0 &&
                 lk_zone_acc == '0 && lk_perm == '0 && !lk_size_err));

  p_err_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_size_err |-> lk_hit);

  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_size_log2 >= 5'd10 && lk_size_log2 <= 5'd24 && !lk_size_log2[0]));

  p_valid_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_vec[lk_idx]);

  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (match_vec[lk_idx] &&
                ((match_vec & ((N'(1) << lk_idx) - N'(1))) == '0)));

  p_any_match_hits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|match_vec) |-> lk_hit);

  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_vec));

  p_pa_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_pa & ~PA_MASK) == '0);

endmodule

bind tlb_lookup tlb_lookup_chk #(
  .N       (ENTRIES),
  .IDX_W   (IDX_W),
  .PA_W    (PA_W),
  .PA_MASK (PA_MASK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync),
  .wr_en        (wr_en),
  .lk_hit       (lk_hit),
  .lk_idx       (lk_idx),
  .lk_pa        (lk_pa),
  .lk_size_log2 (lk_size_log2),
  .lk_zone_acc  (lk_zone_acc),
  .lk_perm      (lk_perm),
  .lk_size_err  (lk_size_err),
  .valid_vec    (ent_valid),
  .match_vec    (ent_match)
);

// File: tb/tlb_lookup_bench.sv
module tlb_lookup_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        wr_sel;
  logic [5:0]  wr_idx;
  logic [63:0] wr_word;
  logic [7:0]  cur_pid;
  logic [31:0] zone_prot;
  logic [31:0] lk_vaddr;
  logic        lk_hit;
  logic [5:0]  lk_idx;
  logic [39:0] lk_pa;
  logic [4:0]  lk_size_log2;
  logic [1:0]  lk_zone_acc;
  logic [1:0]  lk_perm;
  logic        lk_size_err;

  tlb_lookup u_tlb_lookup (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_idx       (wr_idx),
    .wr_word      (wr_word),
    .cur_pid      (cur_pid),
    .zone_prot    (zone_prot),
    .lk_vaddr     (lk_vaddr),
    .lk_hit       (lk_hit),
    .lk_idx       (lk_idx),
    .lk_pa        (lk_pa),
    .lk_size_log2 (lk_size_log2),
    .lk_zone_acc  (lk_zone_acc),
    .lk_perm      (lk_perm),
    .lk_size_err  (lk_size_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    logic        hit;
    logic [5:0]  idx;
    logic [39:0] pa;
    logic [4:0]  lg;
    logic [1:0]  acc;
    logic [1:0]  perm;
    logic        err;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_run;
  int   n_fail;
  bit   done;

  function automatic logic [63:0] tagw(input logic [31:0] va, input logic [2:0] c, input logic v);
    return {32'h0, va[31:10], c, v, 6'h0};
  endfunction

  function automatic logic [63:0] dataw(input logic [39:0] pa, input logic [1:0] p, input logic [3:0] z);
    return {24'h0, pa[39:10], p, z, 4'h0};
  endfunction

  task automatic push(input logic h, input logic [5:0] i, input logic [39:0] pa,
                      input logic [4:0] lg, input logic [1:0] acc, input logic [1:0] perm,
                      input logic err, input string req);
    exp_t e;
    e.hit = h; e.idx = i; e.pa = pa; e.lg = lg; e.acc = acc;
    e.perm = perm; e.err = err; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic wr(input logic [5:0] idx, input logic sel, input logic [63:0] w,
                    input logic [7:0] pid);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_word = w; cur_pid = pid;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] pid,
                      input logic h, input logic [5:0] i, input logic [39:0] pa,
                      input logic [4:0] lg, input logic [1:0] acc, input logic [1:0] perm,
                      input logic err, input string req);
    @(negedge clk);
    wr_en = 1'b0; lk_vaddr = va; cur_pid = pid;
    push(h, i, pa, lg, acc, perm, err, req);
  endtask

  task automatic miss(input logic [31:0] va, input logic [7:0] pid, input string req);
    look(va, pid, 1'b0, 6'd0, 40'h0, 5'd0, 2'd0, 2'd0, 1'b0, req);
  endtask

  // monitor: sample just after the falling edge, away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_run++;
        if (lk_hit !== e.hit || lk_idx !== e.idx || lk_pa !== e.pa ||
            lk_size_log2 !== e.lg || lk_zone_acc !== e.acc ||
            lk_perm !== e.perm || lk_size_err !== e.err) begin
          n_fail++;
          $display("FAIL %s: got hit=%0b idx=%0d pa=%h lg=%0d acc=%0d perm=%0d err=%0b exp hit=%0b idx=%0d pa=%h lg=%0d acc=%0d perm=%0d err=%0b",
                   e.req, lk_hit, lk_idx, lk_pa, lk_size_log2, lk_zone_acc, lk_perm, lk_size_err,
                   e.hit, e.idx, e.pa, e.lg, e.acc, e.perm, e.err);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_idx = '0; wr_word = '0;
    cur_pid = '0; zone_prot = 32'h0000_C0C4; lk_vaddr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 / R11: empty after reset
    miss(32'h0001_2ABC, 8'h00, "R1");
    miss(32'hFFFF_FFFF, 8'h12, "R11");

    // 4 KB global entry, zone 3 -> code 3
    wr(6'd5, 1'b0, tagw(32'h0001_2000, 3'd1, 1'b1), 8'h00);
    wr(6'd5, 1'b1, dataw(40'h12_3456_7000, 2'b10, 4'd3), 8'h00);
    look(32'h0001_2ABC, 8'h33, 1'b1, 6'd5, 40'h02_3456_7000, 5'd12, 2'd3, 2'd2, 1'b0, "R7");
    miss(32'h0001_3000, 8'h33, "R3");
    miss(32'h0001_1FFF, 8'h33, "R3");

    // 64 KB entry owned by pid 0x44, zone 9 above limit
    wr(6'd9, 1'b0, tagw(32'h0040_0000, 3'd3, 1'b1), 8'h44);
    wr(6'd9, 1'b1, dataw(40'h00_8000_0000, 2'b01, 4'd9), 8'h44);
    look(32'h0040_FFFC, 8'h44, 1'b1, 6'd9, 40'h00_8000_0000, 5'd16, 2'd1, 2'd1, 1'b0, "R6");
    miss(32'h0040_FFFC, 8'h45, "R4");

    // overlap: 1 MB at 20, 16 KB at 12
    wr(6'd20, 1'b0, tagw(32'h0100_0000, 3'd5, 1'b1), 8'h00);
    wr(6'd20, 1'b1, dataw(40'h01_0000_0000, 2'b00, 4'd0), 8'h00);
    wr(6'd12, 1'b0, tagw(32'h0100_4000, 3'd2, 1'b1), 8'h00);
    wr(6'd12, 1'b1, dataw(40'h00_0020_0000, 2'b11, 4'd1), 8'h00);
    look(32'h0100_5000, 8'h10, 1'b1, 6'd12, 40'h00_0020_0000, 5'd14, 2'd1, 2'd3, 1'b0, "R8");
    look(32'h0100_8000, 8'h10, 1'b1, 6'd20, 40'h01_0000_0000, 5'd20, 2'd0, 2'd0, 1'b0, "R8");

    // 1 KB page flags size error
    wr(6'd30, 1'b0, tagw(32'h0200_0400, 3'd0, 1'b1), 8'h00);
    wr(6'd30, 1'b1, dataw(40'h00_0000_0400, 2'b00, 4'd2), 8'h00);
    look(32'h0200_07FF, 8'h00, 1'b1, 6'd30, 40'h00_0000_0400, 5'd10, 2'd0, 2'd0, 1'b1, "R9");
    miss(32'h0200_0800, 8'h00, "R3");

    // 16 MB page, zone 7 equals limit
    wr(6'd63, 1'b0, tagw(32'h0A00_0000, 3'd7, 1'b1), 8'h00);
    wr(6'd63, 1'b1, dataw(40'h03_0000_0000, 2'b01, 4'd7), 8'h00);
    look(32'h0AFF_FFFF, 8'h99, 1'b1, 6'd63, 40'h03_0000_0000, 5'd24, 2'd3, 2'd1, 1'b0, "R6");
    miss(32'h0B00_0000, 8'h99, "R3");

    // R5: tag write captures pid, data write does not
    wr(6'd40, 1'b0, tagw(32'h0300_0000, 3'd1, 1'b1), 8'h7E);
    wr(6'd40, 1'b1, dataw(40'h00_0300_0000, 2'b00, 4'd0), 8'h01);
    look(32'h0300_0004, 8'h7E, 1'b1, 6'd40, 40'h00_0300_0000, 5'd12, 2'd0, 2'd0, 1'b0, "R5");
    miss(32'h0300_0004, 8'h01, "R5");

    // R10: invalidating write and lookup in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_idx = 6'd9;
    wr_word = tagw(32'h0040_0000, 3'd3, 1'b0); cur_pid = 8'h44; lk_vaddr = 32'h0040_0010;
    push(1'b1, 6'd9, 40'h00_8000_0000, 5'd16, 2'd1, 2'd1, 1'b0, "R10");
    miss(32'h0040_0010, 8'h44, "R2");

    // data rewrite, high address bits removed by mask, zone 15 clamped
    wr(6'd5, 1'b1, dataw(40'hFF_0000_1000, 2'b11, 4'd15), 8'h00);
    look(32'h0001_2000, 8'h33, 1'b1, 6'd5, 40'h0F_0000_1000, 5'd12, 2'd1, 2'd3, 1'b0, "R7");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule